// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block evaluates arithmetic expressions for a zero-address machine. Operands are pushed, operators consume the two topmost entries and push one result, and pops discard the top. The stack has no fixed depth from the program's point of view. The `REG_N` entries nearest the top are held in registers. Older entries move into a private synchronous RAM of `MEM_DEPTH` words. Data moves between the registers and the RAM only when the registers overflow or when the register portion would otherwise run short.

Commands arrive on a valid/ready port. A command is taken on a rising edge where both `cmd_valid` and `cmd_ready` are high. The unit drops `cmd_ready` for one cycle each time it touches the RAM. While `cmd_ready` is low, the command fields are not sampled, and the source must keep its command steady until the handshake completes.

Refills are eager. After a pop or an operator, if any entries sit in the RAM, the most recently spilled one is read back into the bottom register slot. Because of this, the register portion is always full while the RAM holds data.

Two saturating counters record every implicit store and every implicit load. The topmost value, the total depth and three sticky error flags are plain outputs.

Top module: `stk_eval_unit`

## Requirements
- R1: After reset the unit shows the following state: `stack_depth` 0, `tos_data` 0, all three error flags low, both counters 0, and `cmd_ready` high.
- R2: A push (`cmd_op` 000) puts `cmd_data` on top of the stack and raises `stack_depth` by one.
- R3: `cmd_op` values 100, 101, 110 and 111 select add, subtract, multiply and divide. Each takes the second entry as the left operand and the top entry as the right operand, uses unsigned arithmetic, and keeps the low `DATA_W` bits. It replaces both entries with the result, so depth falls by one. Codes 010 and 011 are accepted and change nothing.
- R4: A pop (`cmd_op` 001) removes the top entry and lowers `stack_depth` by one.
- R5: A push that finds all `REG_N` register slots occupied causes a spill. The deepest register entry is written to RAM, the store counter increments, and `cmd_ready` is held low for exactly one cycle.
- R6: After a pop or an operator leaves entries in RAM, the most recently spilled entry is read back below the register entries. The load counter increments and `cmd_ready` is held low for exactly one cycle. The RAM is accessed in no other case.
- R7: With `REG_N`=2, the sequence a b c * + a d c * + e - / yields (a+b*c)/(a+d*c-e). It makes 4 implicit stores and 4 implicit loads.
- R8: With `REG_N`=4, the same sequence gives the same result with no implicit store or load.
- R9: A pop on an empty stack, or an operator with fewer than two entries, sets the sticky `underflow_err`. Depth and top value stay unchanged.
- R10: A push when the depth equals `REG_N`+`MEM_DEPTH` sets the sticky `overflow_err`. The push is dropped.
- R11: Division by zero produces the result 0 and sets the sticky `divzero_err`.
- R12: `spill_count` and `fill_count` stop at 2^`CNT_W`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_op | input | 3 | Command code (see R2, R3, R4) |
| cmd_data | input | DATA_W | Value for a push |
| tos_data | output | DATA_W | Top entry, 0 when empty |
| stack_depth | output | clog2(REG_N+MEM_DEPTH+1) | Entries held in total |
| underflow_err | output | 1 | Sticky underflow flag |
| overflow_err | output | 1 | Sticky overflow flag |
| divzero_err | output | 1 | Sticky divide-by-zero flag |
| spill_count | output | CNT_W | Implicit stores, saturating |
| fill_count | output | CNT_W | Implicit loads, saturating |

## Verification
The assertions assume three things about the inputs: `cmd_op` is known whenever `cmd_valid` is high, reset is held for at least one edge, and `REG_N` is at least 2. The last point matters because the invariant that the registers are full while the RAM holds data relies on an operator never needing more than what the registers hold. The stimulus sets every field in the same negative-edge step as `cmd_valid`. It holds them until `cmd_ready` has been seen high at an edge, then drops valid. It never drives the unit from a state that a real command stream could not reach.

// File: rtl/stk_pkg.sv
package stk_pkg;

  // Operation applied to the register cache in one cycle
  typedef enum logic [2:0] {
    RC_HOLD,
    RC_PUSH,   // write above the current top
    RC_POP,    // drop the top
    RC_BIN,    // replace top two with one value
    RC_SHDN,   // spill: discard bottom, shift toward bottom
    RC_SHUP    // fill: shift toward top, insert at bottom
  } rc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,   // spill done, push pending
    ST_FILL    // read issued, data lands this cycle
  } ctl_state_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 16
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] result,
  output logic         div_zero
);

  always_comb begin
    div_zero = 1'b0;
    unique case (sel)
      2'b00: result = lhs + rhs;
      2'b01: result = lhs - rhs;
      2'b10: result = lhs * rhs;
      default: begin
        if (rhs == '0) begin
          result   = '0;
          div_zero = 1'b1;
        end else begin
          result = lhs / rhs;
        end
      end
    endcase
  end

endmodule

// File: rtl/stk_spill_ram.sv
module stk_spill_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem_q[rd_addr];
  end

  // Spill and fill never share a cycle: one RAM access per stall
  assert_single_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

endmodule

// File: rtl/stk_reg_cache.sv
module stk_reg_cache
  import stk_pkg::*;
#(
  parameter int N  = 2,
  parameter int W  = 16,
  localparam int CW = $clog2(N + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rc_op_e        op,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  top_val,
  output logic [W-1:0]  sec_val,
  output logic [W-1:0]  bot_val,
  output logic [CW-1:0] cnt
);

  logic [W-1:0]  ent_q [N];
  logic [W-1:0]  ent_d [N];
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_d[i] = ent_q[i];
      unique case (op)
        RC_PUSH: if (i == int'(cnt_q)) ent_d[i] = wdata;
        RC_BIN:  if (i + 2 == int'(cnt_q)) ent_d[i] = wdata;
        RC_SHDN: if (i < N - 1) ent_d[i] = ent_q[(i + 1) % N];
        RC_SHUP: ent_d[i] = (i == 0) ? wdata : ent_q[(i + N - 1) % N];
        default: ;
      endcase
    end
    unique case (op)
      RC_PUSH, RC_SHUP:        cnt_d = cnt_q + 1'b1;
      RC_POP, RC_BIN, RC_SHDN: cnt_d = cnt_q - 1'b1;
      default:                 cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < N; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign top_val = (cnt_q == '0) ? '0 : ent_q[IW'(cnt_q - 1'b1)];
  assign sec_val = (cnt_q < CW'(2)) ? '0 : ent_q[IW'(cnt_q - CW'(2))];
  assign bot_val = ent_q[0];
  assign cnt     = cnt_q;

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(N));
  assert_push_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RC_PUSH) |-> (cnt_q < CW'(N)));
  assert_bin_operands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RC_BIN) |-> (cnt_q >= CW'(2)));

endmodule

// File: rtl/stk_eval_unit.sv
module stk_eval_unit
  import stk_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int REG_N     = 2,
  parameter int MEM_DEPTH = 16,
  parameter int CNT_W     = 8,
  localparam int CAP = REG_N + MEM_DEPTH,
  localparam int DW  = $clog2(CAP + 1),
  localparam int MPW = $clog2(MEM_DEPTH + 1),
  localparam int AW  = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
  localparam int CW  = $clog2(REG_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] tos_data,
  output logic [DW-1:0]     stack_depth,
  output logic              underflow_err,
  output logic              overflow_err,
  output logic              divzero_err,
  output logic [CNT_W-1:0]  spill_count,
  output logic [CNT_W-1:0]  fill_count
);

  if (REG_N < 2) begin : g_bad_reg_n
    $error("stk_eval_unit needs REG_N of at least 2");
  end

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  ctl_state_e        state_q, state_d;
  logic [MPW-1:0]    msp_q, msp_d;
  logic [DATA_W-1:0] held_q, held_d;
  rc_op_e            rc_op;
  logic [DATA_W-1:0] rc_wdata, top_val, sec_val, bot_val, alu_res, ram_rd_data;
  logic [CW-1:0]     reg_cnt;
  logic              alu_dz, ram_wr_en, ram_rd_en, fire;
  logic              set_udf, set_ovf, set_dz;

  stk_reg_cache #(.N(REG_N), .W(DATA_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .op(rc_op), .wdata(rc_wdata),
    .top_val(top_val), .sec_val(sec_val), .bot_val(bot_val), .cnt(reg_cnt)
  );

  stk_alu #(.W(DATA_W)) u_alu (
    .sel(cmd_op[1:0]), .lhs(sec_val), .rhs(top_val),
    .result(alu_res), .div_zero(alu_dz)
  );

  stk_spill_ram #(.W(DATA_W), .DEPTH(MEM_DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ram_wr_en), .wr_addr(AW'(msp_q)), .wr_data(bot_val),
    .rd_en(ram_rd_en), .rd_addr(AW'(msp_q - 1'b1)), .rd_data(ram_rd_data)
  );

  assign stack_depth = DW'(reg_cnt) + DW'(msp_q);
  assign cmd_ready   = (state_q == ST_IDLE);
  assign fire        = cmd_valid && cmd_ready;
  assign tos_data    = top_val;

  always_comb begin
    state_d   = state_q;
    msp_d     = msp_q;
    held_d    = held_q;
    rc_op     = RC_HOLD;
    rc_wdata  = cmd_data;
    ram_wr_en = 1'b0;
    ram_rd_en = 1'b0;
    set_udf   = 1'b0;
    set_ovf   = 1'b0;
    set_dz    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (fire) begin
        if (cmd_op[2]) begin
          if (stack_depth < DW'(2)) begin
            set_udf = 1'b1;
          end else begin
            rc_op    = RC_BIN;
            rc_wdata = alu_res;
            set_dz   = alu_dz;
          end
        end else if (cmd_op[1:0] == 2'b00) begin
          if (stack_depth == DW'(CAP)) begin
            set_ovf = 1'b1;
          end else if (reg_cnt == CW'(REG_N)) begin
            ram_wr_en = 1'b1;
            rc_op     = RC_SHDN;
            msp_d     = msp_q + 1'b1;
            held_d    = cmd_data;
            state_d   = ST_PUSH;
          end else begin
            rc_op = RC_PUSH;
          end
        end else if (cmd_op[1:0] == 2'b01) begin
          if (stack_depth == '0) set_udf = 1'b1;
          else                   rc_op   = RC_POP;
        end
        // Eager refill once the register portion has given up a slot
        if ((rc_op == RC_POP || rc_op == RC_BIN) && msp_q != '0) begin
          ram_rd_en = 1'b1;
          msp_d     = msp_q - 1'b1;
          state_d   = ST_FILL;
        end
      end
      ST_PUSH: begin
        rc_op    = RC_PUSH;
        rc_wdata = held_q;
        state_d  = ST_IDLE;
      end
      ST_FILL: begin
        rc_op    = RC_SHUP;
        rc_wdata = ram_rd_data;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      msp_q         <= '0;
      held_q        <= '0;
      underflow_err <= 1'b0;
      overflow_err  <= 1'b0;
      divzero_err   <= 1'b0;
      spill_count   <= '0;
      fill_count    <= '0;
    end else begin
      state_q <= state_d;
      msp_q   <= msp_d;
      held_q  <= held_d;
      if (set_udf) underflow_err <= 1'b1;
      if (set_ovf) overflow_err  <= 1'b1;
      if (set_dz)  divzero_err   <= 1'b1;
      if (ram_wr_en && spill_count != CNT_MAX) spill_count <= spill_count + 1'b1;
      if (ram_rd_en && fill_count  != CNT_MAX) fill_count  <= fill_count + 1'b1;
    end
  end

  assert_push_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == 3'b000 && reg_cnt < CW'(REG_N))
      |=> (stack_depth == $past(stack_depth) + DW'(1)));
  assert_spill_only_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> (reg_cnt == CW'(REG_N)));
  assert_stall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> cmd_ready);
  assert_cache_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && msp_q != '0) |-> (reg_cnt == CW'(REG_N)));
  assert_udf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);
  assert_udf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == 3'b001 && stack_depth == '0) |=> (stack_depth == '0));
  assert_ovf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == 3'b000 && stack_depth == DW'(CAP)) |=> $stable(stack_depth));
  assert_count_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_count == CNT_MAX) |=> (spill_count == CNT_MAX));

endmodule

// File: tb/stk_eval_unit_tb.sv
`timescale 1ns/1ps
module stk_eval_unit_tb_top;

  localparam int DEPTH_M = 16;
  localparam int DWA = $clog2(2 + DEPTH_M + 1);
  localparam int DWB = $clog2(4 + DEPTH_M + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  vld = 2'b00;
  logic [1:0]  rdy;
  logic [2:0]  c_op = 3'b000;
  logic [15:0] c_data = 16'd0;
  logic [15:0] tos_w [2];
  logic [DWA-1:0] dep_a;
  logic [DWB-1:0] dep_b;
  logic [1:0]  udf_w, ovf_w, dz_w;
  logic [7:0]  sp_w [2];
  logic [7:0]  fl_w [2];

  stk_eval_unit #(.DATA_W(16), .REG_N(2), .MEM_DEPTH(DEPTH_M), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(vld[0]), .cmd_ready(rdy[0]),
    .cmd_op(c_op), .cmd_data(c_data), .tos_data(tos_w[0]), .stack_depth(dep_a),
    .underflow_err(udf_w[0]), .overflow_err(ovf_w[0]), .divzero_err(dz_w[0]),
    .spill_count(sp_w[0]), .fill_count(fl_w[0])
  );

  stk_eval_unit #(.DATA_W(16), .REG_N(4), .MEM_DEPTH(DEPTH_M), .CNT_W(8)) dut4_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(vld[1]), .cmd_ready(rdy[1]),
    .cmd_op(c_op), .cmd_data(c_data), .tos_data(tos_w[1]), .stack_depth(dep_b),
    .underflow_err(udf_w[1]), .overflow_err(ovf_w[1]), .divzero_err(dz_w[1]),
    .spill_count(sp_w[1]), .fill_count(fl_w[1])
  );

  localparam logic [2:0] PU = 3'b000, PO = 3'b001, NP = 3'b010,
                         AD = 3'b100, SB = 3'b101, ML = 3'b110, DV = 3'b111;

  // {op, push data, expected top, expected depth, expected stalls for REG_N=2}
  localparam logic [41:0] VEC [13] = '{
    {PU, 16'd3, 16'd3,  5'd1, 2'd0},
    {PU, 16'd5, 16'd5,  5'd2, 2'd0},
    {PU, 16'd7, 16'd7,  5'd3, 2'd1},
    {ML, 16'd0, 16'd35, 5'd2, 2'd1},
    {AD, 16'd0, 16'd38, 5'd1, 2'd0},
    {PU, 16'd3, 16'd3,  5'd2, 2'd0},
    {PU, 16'd2, 16'd2,  5'd3, 2'd1},
    {PU, 16'd7, 16'd7,  5'd4, 2'd1},
    {ML, 16'd0, 16'd14, 5'd3, 2'd1},
    {AD, 16'd0, 16'd17, 5'd2, 2'd1},
    {PU, 16'd4, 16'd4,  5'd3, 2'd1},
    {SB, 16'd0, 16'd13, 5'd2, 2'd1},
    {DV, 16'd0, 16'd2,  5'd1, 2'd0}
  };

  int checks = 0;
  int fails  = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] depth_of(input int which);
    return (which == 0) ? 32'(dep_a) : 32'(dep_b);
  endfunction

  task automatic issue(input int which, input logic [2:0] op, input logic [15:0] data,
                       output int stalls);
    @(negedge clk);
    c_op = op;
    c_data = data;
    vld[which] = 1'b1;
    while (!rdy[which]) @(negedge clk);
    @(negedge clk);
    vld[which] = 1'b0;
    stalls = 0;
    while (!rdy[which]) begin
      stalls++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int st;
    do_reset();
    // R1 reset state on both instances
    for (int w = 0; w < 2; w++) begin
      check("R1 depth", depth_of(w), 0);
      check("R1 tos", 32'(tos_w[w]), 0);
      check("R1 flags", {udf_w[w], ovf_w[w], dz_w[w]}, 0);
      check("R1 counters", {sp_w[w], fl_w[w]}, 0);
      check("R1 ready", 32'(rdy[w]), 1);
    end

    // Table walk: R2/R3/R4 values, R5/R6 stalls, on both cache sizes
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 13; k++) begin
        issue(w, VEC[k][41:39], VEC[k][38:23], st);
        check("R2/R3 tos", 32'(tos_w[w]), 32'(VEC[k][22:7]));
        check("R2/R4 depth", depth_of(w), 32'(VEC[k][6:2]));
        check("R5/R6 stall", st, (w == 0) ? 32'(VEC[k][1:0]) : 0);
      end
    end
    check("R7 stores", 32'(sp_w[0]), 4);
    check("R7 loads", 32'(fl_w[0]), 4);
    check("R8 stores", 32'(sp_w[1]), 0);
    check("R8 loads", 32'(fl_w[1]), 0);

    // Operator order, divide by zero, no-op code, operator underflow
    do_reset();
    issue(0, PU, 16'd9, st);
    issue(0, PU, 16'd0, st);
    issue(0, DV, 16'd0, st);
    check("R11 result", 32'(tos_w[0]), 0);
    check("R11 flag", 32'(dz_w[0]), 1);
    issue(0, PU, 16'd20, st);
    issue(0, SB, 16'd0, st);
    check("R3 sub order", 32'(tos_w[0]), 32'(16'hFFEC));
    issue(0, NP, 16'd77, st);
    check("R3 noop tos", 32'(tos_w[0]), 32'(16'hFFEC));
    check("R3 noop depth", depth_of(0), 1);
    issue(0, AD, 16'd0, st);
    check("R9 bin underflow flag", 32'(udf_w[0]), 1);
    check("R9 bin keeps tos", 32'(tos_w[0]), 32'(16'hFFEC));
    check("R9 bin keeps depth", depth_of(0), 1);
    issue(0, PO, 16'd0, st);
    check("R4 pop to empty", depth_of(0), 0);
    issue(0, PO, 16'd0, st);
    check("R9 pop empty depth", depth_of(0), 0);
    check("R9 sticky", 32'(udf_w[0]), 1);

    // Fill to capacity, overflow, then drain in order through the RAM
    do_reset();
    check("R9 cleared by reset", 32'(udf_w[0]), 0);
    for (int k = 1; k <= 18; k++) issue(0, PU, 16'(100 + k), st);
    check("R5 full depth", depth_of(0), 18);
    issue(0, PU, 16'd999, st);
    check("R10 flag", 32'(ovf_w[0]), 1);
    check("R10 depth kept", depth_of(0), 18);
    check("R10 tos kept", 32'(tos_w[0]), 118);
    for (int k = 17; k >= 1; k--) begin
      issue(0, PO, 16'd0, st);
      check("R6 drain order", 32'(tos_w[0]), 32'(100 + k));
    end
    issue(0, PO, 16'd0, st);
    check("R4 drained", depth_of(0), 0);
    check("R5 spill total", 32'(sp_w[0]), 16);
    check("R6 fill total", 32'(fl_w[0]), 16);

    // Counter saturation
    issue(0, PU, 16'd1, st);
    issue(0, PU, 16'd2, st);
    for (int k = 0; k < 260; k++) begin
      issue(0, PU, 16'd3, st);
      issue(0, PO, 16'd0, st);
    end
    check("R12 store sat", 32'(sp_w[0]), 255);
    check("R12 load sat", 32'(fl_w[0]), 255);
    check("R12 data intact", 32'(tos_w[0]), 2);

    summary();
    $finish;
  end

endmodule